// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block is the combinational bypass-select logic of a five-stage in-order integer pipeline. It takes the source register fields of the instruction sitting in the execute stage. It compares them against the destination register of the producer held in the execute/memory pipeline register and of the producer held in the memory/writeback pipeline register. From that comparison it produces mux select codes for the two ALU operand inputs. Because register reads happen in decode and writes happen in writeback, only read-after-write dependences need bypassing.

A third select steers the data-memory write-data input. When a store has reached the memory stage and the instruction one slot older is a load that is now in writeback, the loaded value is routed straight to the store. This lets a load feed a following store with no stall. ALU results reach store data earlier, through the second ALU operand path, while the store is still in execute.

Stall generation for a load followed by an immediate use lies outside this block. So do the register file, the ALU and the branch logic. For that load-use case, this unit only refuses to select a load that is still in the execute/memory register.

Top module: `operand_bypass_unit`

## Requirements
- R1: The first source register is the 5-bit field at instruction bits [25:21] and the second is the field at bits [20:16] of the 32-bit execute-stage instruction word; no other instruction bit affects any select.
- R2: Select codes are 2 bits: 2'b00 register file, 2'b01 memory/writeback value, 2'b10 execute/memory value. An operand whose source matches a writing, non-load execute/memory producer gets 2'b10, independently for operand A and operand B.
- R3: An operand whose source matches a writing memory/writeback producer gets 2'b01, whether that producer is an ALU operation or a load, provided no eligible execute/memory match exists.
- R4: When both producers match the same source, the execute/memory (younger) producer wins and the select is 2'b10.
- R5: Register 0 is never bypassed: a destination of 0 gives no match for any of the three selects.
- R6: A producer whose write-enable is low is ignored by all three selects.
- R7: A load held in the execute/memory register is never selected (its data does not yet exist); the operand falls back to a memory/writeback match (2'b01) or to the register file (2'b00).
- R8: The store-data select is 2'b01 exactly when the execute/memory instruction is a store, the memory/writeback instruction is a writing load with a nonzero destination, and that destination equals the store's data register; otherwise it is 2'b00.
- R9: A non-load memory/writeback producer never drives the store-data select, since its value reached the store through operand B one cycle earlier.
- R10: With no match at all, every select is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_instr | input | 32 | Instruction word in the execute stage |
| exmem_rd | input | 5 | Destination register of the execute/memory producer |
| exmem_wr | input | 1 | Execute/memory producer writes a register |
| exmem_load | input | 1 | Execute/memory instruction is a load |
| exmem_store | input | 1 | Execute/memory instruction is a store |
| exmem_store_reg | input | 5 | Data register of the store in execute/memory |
| memwb_rd | input | 5 | Destination register of the memory/writeback producer |
| memwb_wr | input | 1 | Memory/writeback producer writes a register |
| memwb_load | input | 1 | Memory/writeback instruction is a load |
| sel_alu_a | output | 2 | Select for ALU operand A |
| sel_alu_b | output | 2 | Select for ALU operand B |
| sel_store | output | 2 | Select for data-memory write data |

## Verification
An ALU operand bypass and the load-to-store bypass can be active in the same cycle. This happens when a load in writeback matches both a source of the instruction in execute and the data register of the store in memory. The vector table includes such a row, where operand A gets 2'b01 from the same producer that drives the store-data select. The row also shows that the two paths do not mask each other. Priority collisions are provoked by giving both producers the same destination, and judged by expecting 2'b10 on both operands.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_MEMWB   = 2'b01,
      SRC_EXMEM   = 2'b10
   } src_sel_e;
endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
   parameter int RW         = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [RW-1:0] src,
   input  logic [RW-1:0] dst,
   input  logic          wr,
   input  logic          allow,
   output logic          hit
);
   logic same;
   assign same = (src == dst);

   generate
      if (ZERO_GUARD) begin : g_guard
         assign hit = allow & wr & (dst != '0) & same;
      end else begin : g_noguard
         assign hit = allow & wr & same;
      end
   endgenerate
endmodule

// File: rtl/bypass_src_sel.sv
module bypass_src_sel
   import bypass_pkg::*;
#(
   parameter int RW = 5
) (
   input  logic [RW-1:0] src,
   input  logic [RW-1:0] em_rd,
   input  logic          em_wr,
   input  logic          em_load,
   input  logic [RW-1:0] mw_rd,
   input  logic          mw_wr,
   output src_sel_e      sel
);
   logic em_hit, mw_hit;

   bypass_match #(.RW(RW), .ZERO_GUARD(1'b1)) u_em (
      .src(src), .dst(em_rd), .wr(em_wr), .allow(~em_load), .hit(em_hit));
   bypass_match #(.RW(RW), .ZERO_GUARD(1'b1)) u_mw (
      .src(src), .dst(mw_rd), .wr(mw_wr), .allow(1'b1), .hit(mw_hit));

   always_comb begin
      if (em_hit)      sel = SRC_EXMEM;
      else if (mw_hit) sel = SRC_MEMWB;
      else             sel = SRC_REGFILE;
   end

   always_comb begin
      // R4: a younger match must never lose to the older one
      a_r4_younger_wins: assert (!(em_hit && mw_hit) || sel == SRC_EXMEM)
         else $error("younger producer lost priority");
      // R7: a load still in execute/memory never selected
      a_r7_no_em_load: assert (!(em_load && sel == SRC_EXMEM))
         else $error("load in execute/memory was selected");
   end
endmodule

// File: rtl/bypass_store_sel.sv
module bypass_store_sel
   import bypass_pkg::*;
#(
   parameter int RW           = 5,
   parameter bit STORE_BYPASS = 1'b1
) (
   input  logic [RW-1:0] st_reg,
   input  logic          em_store,
   input  logic [RW-1:0] mw_rd,
   input  logic          mw_wr,
   input  logic          mw_load,
   output src_sel_e      sel
);
   generate
      if (STORE_BYPASS) begin : g_on
         logic hit;
         bypass_match #(.RW(RW), .ZERO_GUARD(1'b1)) u_mw (
            .src(st_reg), .dst(mw_rd), .wr(mw_wr),
            .allow(em_store & mw_load), .hit(hit));
         assign sel = hit ? SRC_MEMWB : SRC_REGFILE;
      end else begin : g_off
         assign sel = SRC_REGFILE;
      end
   endgenerate

   always_comb begin
      // R9: only a load in writeback may feed the store data
      a_r9_load_only: assert (sel != SRC_MEMWB || (mw_load && em_store))
         else $error("store bypass from non-load");
      a_r8_code_range: assert (sel == SRC_REGFILE || sel == SRC_MEMWB)
         else $error("illegal store select");
   end
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
   import bypass_pkg::*;
#(
   parameter int ILEN         = 32,
   parameter int RW           = 5,
   parameter int RS1_LSB      = 21,
   parameter int RS2_LSB      = 16,
   parameter bit STORE_BYPASS = 1'b1
) (
   input  logic [ILEN-1:0] ex_instr,
   input  logic [RW-1:0]   exmem_rd,
   input  logic            exmem_wr,
   input  logic            exmem_load,
   input  logic            exmem_store,
   input  logic [RW-1:0]   exmem_store_reg,
   input  logic [RW-1:0]   memwb_rd,
   input  logic            memwb_wr,
   input  logic            memwb_load,
   output logic [1:0]      sel_alu_a,
   output logic [1:0]      sel_alu_b,
   output logic [1:0]      sel_store
);
   localparam int NSRC = 2;
   localparam int LSB [NSRC] = '{RS1_LSB, RS2_LSB};

   generate
      if (RW < 1 || RW > 8) begin : g_bad_rw
         $error("RW out of range");
      end
      if (RS1_LSB + RW > ILEN || RS2_LSB + RW > ILEN) begin : g_bad_field
         $error("source field exceeds instruction width");
      end
   endgenerate

   logic [RW-1:0] src [NSRC];
   src_sel_e      sel [NSRC];
   src_sel_e      st_sel;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         assign src[gi] = ex_instr[LSB[gi] +: RW];
         bypass_src_sel #(.RW(RW)) u_sel (
            .src(src[gi]), .em_rd(exmem_rd), .em_wr(exmem_wr),
            .em_load(exmem_load), .mw_rd(memwb_rd), .mw_wr(memwb_wr),
            .sel(sel[gi]));
      end
   endgenerate

   bypass_store_sel #(.RW(RW), .STORE_BYPASS(STORE_BYPASS)) u_st (
      .st_reg(exmem_store_reg), .em_store(exmem_store), .mw_rd(memwb_rd),
      .mw_wr(memwb_wr), .mw_load(memwb_load), .sel(st_sel));

   assign sel_alu_a = sel[0];
   assign sel_alu_b = sel[1];
   assign sel_store = st_sel;

   always_comb begin
      // R5: register 0 sources always read the register file
      a_r5_zero_a: assert (src[0] != '0 || sel_alu_a == 2'b00)
         else $error("register 0 bypassed on A");
      a_r5_zero_b: assert (src[1] != '0 || sel_alu_b == 2'b00)
         else $error("register 0 bypassed on B");
      // R6: with no writer anywhere, nothing is bypassed
      a_r6_no_writer: assert (exmem_wr || memwb_wr ||
                              (sel_alu_a == 2'b00 && sel_alu_b == 2'b00 && sel_store == 2'b00))
         else $error("bypass without a writer");
      // R2: codes stay within the three legal values
      a_r2_legal_a: assert (sel_alu_a != 2'b11) else $error("illegal code A");
      a_r2_legal_b: assert (sel_alu_b != 2'b11) else $error("illegal code B");
   end
endmodule

// File: tb/operand_bypass_unit_test.sv
module operand_bypass_unit_test;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [31:0] ex_instr;
   logic [4:0]  exmem_rd, exmem_store_reg, memwb_rd;
   logic        exmem_wr, exmem_load, exmem_store, memwb_wr, memwb_load;
   logic [1:0]  sel_alu_a, sel_alu_b, sel_store;

   operand_bypass_unit uut (
      .ex_instr(ex_instr), .exmem_rd(exmem_rd), .exmem_wr(exmem_wr),
      .exmem_load(exmem_load), .exmem_store(exmem_store),
      .exmem_store_reg(exmem_store_reg), .memwb_rd(memwb_rd),
      .memwb_wr(memwb_wr), .memwb_load(memwb_load),
      .sel_alu_a(sel_alu_a), .sel_alu_b(sel_alu_b), .sel_store(sel_store));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // {rs1, rs2, em_rd, em_wr, em_ld, em_st, em_sreg, mw_rd, mw_wr, mw_ld, expA, expB, expS}
   localparam int NV = 16;
   localparam logic [35:0] VEC [NV] = '{
      {5'd1, 5'd2, 5'd1, 1'b1,1'b0,1'b0, 5'd0, 5'd9, 1'b1,1'b0, 2'b10,2'b00,2'b00},   // R2 A
      {5'd3, 5'd4, 5'd4, 1'b1,1'b0,1'b0, 5'd0, 5'd0, 1'b0,1'b0, 2'b00,2'b10,2'b00},   // R2 B
      {5'd5, 5'd6, 5'd9, 1'b1,1'b0,1'b0, 5'd0, 5'd5, 1'b1,1'b0, 2'b01,2'b00,2'b00},   // R3 ALU
      {5'd5, 5'd6, 5'd9, 1'b1,1'b0,1'b0, 5'd0, 5'd6, 1'b1,1'b1, 2'b00,2'b01,2'b00},   // R3 load
      {5'd7, 5'd7, 5'd7, 1'b1,1'b0,1'b0, 5'd0, 5'd7, 1'b1,1'b0, 2'b10,2'b10,2'b00},   // R4
      {5'd0, 5'd0, 5'd0, 1'b1,1'b0,1'b0, 5'd0, 5'd0, 1'b1,1'b1, 2'b00,2'b00,2'b00},   // R5
      {5'd8, 5'd9, 5'd8, 1'b0,1'b0,1'b0, 5'd0, 5'd9, 1'b0,1'b0, 2'b00,2'b00,2'b00},   // R6
      {5'd10,5'd11,5'd10,1'b1,1'b1,1'b0, 5'd0, 5'd10,1'b1,1'b0, 2'b01,2'b00,2'b00},   // R7 fallback
      {5'd12,5'd13,5'd12,1'b1,1'b1,1'b0, 5'd0, 5'd1, 1'b1,1'b0, 2'b00,2'b00,2'b00},   // R7 none
      {5'd2, 5'd3, 5'd0, 1'b0,1'b0,1'b1, 5'd14,5'd14,1'b1,1'b1, 2'b00,2'b00,2'b01},   // R8
      {5'd2, 5'd3, 5'd0, 1'b0,1'b0,1'b1, 5'd15,5'd15,1'b1,1'b0, 2'b00,2'b00,2'b00},   // R9
      {5'd2, 5'd3, 5'd0, 1'b0,1'b0,1'b1, 5'd0, 5'd0, 1'b1,1'b1, 2'b00,2'b00,2'b00},   // R5 store
      {5'd16,5'd3, 5'd0, 1'b0,1'b0,1'b0, 5'd16,5'd16,1'b1,1'b1, 2'b01,2'b00,2'b00},   // R8 no store
      {5'd16,5'd3, 5'd0, 1'b0,1'b0,1'b1, 5'd16,5'd16,1'b1,1'b1, 2'b01,2'b00,2'b01},   // R8 dual path
      {5'd31,5'd0, 5'd31,1'b1,1'b0,1'b1, 5'd17,5'd17,1'b0,1'b1, 2'b10,2'b00,2'b00},   // R1 / R6
      {5'd20,5'd21,5'd22,1'b1,1'b0,1'b0, 5'd0, 5'd23,1'b1,1'b1, 2'b00,2'b00,2'b00}    // R10
   };

   function automatic string tag_of(input int i);
      case (i)
         0, 1:        return "R2";
         2, 3:        return "R3";
         4:           return "R4";
         5, 11:       return "R5";
         6:           return "R6";
         7, 8:        return "R7";
         9, 12, 13:   return "R8";
         10:          return "R9";
         14:          return "R1";
         default:     return "R10";
      endcase
   endfunction

   task automatic compare(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [35:0] v);
      @(negedge clk);
      ex_instr        = {6'h3F, v[35:31], v[30:26], 16'hFFFF};
      exmem_rd        = v[25:21];
      exmem_wr        = v[20];
      exmem_load      = v[19];
      exmem_store     = v[18];
      exmem_store_reg = v[17:13];
      memwb_rd        = v[12:8];
      memwb_wr        = v[7];
      memwb_load      = v[6];
      @(posedge clk);
      #1;
   endtask

   initial begin
      ex_instr = '0; exmem_rd = '0; exmem_wr = 0; exmem_load = 0;
      exmem_store = 0; exmem_store_reg = '0; memwb_rd = '0;
      memwb_wr = 0; memwb_load = 0;
      @(posedge clk); #1;
      // R10: idle inputs give register file everywhere
      compare("R10", "idle A", sel_alu_a, 2'b00);
      compare("R10", "idle B", sel_alu_b, 2'b00);
      compare("R10", "idle S", sel_store, 2'b00);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         compare(tag_of(i), "A", sel_alu_a, VEC[i][5:4]);
         compare(tag_of(i), "B", sel_alu_b, VEC[i][3:2]);
         compare(tag_of(i), "S", sel_store, VEC[i][1:0]);
      end

      // R1: bits outside the fields must not matter
      @(negedge clk);
      ex_instr = {6'h00, 5'd4, 5'd5, 16'h0000};
      exmem_rd = 5'd4; exmem_wr = 1; exmem_load = 0; exmem_store = 0;
      memwb_rd = 5'd5; memwb_wr = 1; memwb_load = 0;
      @(posedge clk); #1;
      compare("R1", "clean A", sel_alu_a, 2'b10);
      compare("R1", "clean B", sel_alu_b, 2'b01);
      @(negedge clk);
      ex_instr = {6'h2A, 5'd4, 5'd5, 16'h5A5A};
      @(posedge clk); #1;
      compare("R1", "filler A", sel_alu_a, 2'b10);
      compare("R1", "filler B", sel_alu_b, 2'b01);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule